// File: doc/BRIEF.md
# Debug Breakpoint Match Unit

This block watches a processor's instruction fetches and data accesses against a small set of programmable breakpoint slots. Each slot holds an address, and a shared control register gives every slot an enable pair, a kind (instruction, data write, data read-or-write, or I/O) and a length. In every cycle the block compares the presented fetch address and data access against all slots. It raises a debug request in that same cycle when an enabled slot hits, or when the core forces an update.

On that same clock edge the low bits of a status register capture which slots hit. A slot that hit is recorded even when it is not enabled. The status register does not change in cycles without an enabled hit or a forced update. All registers are loaded through a small write port selected by an index. Their current values are visible on the block's outputs.

Top module: `bpm_unit`

## Requirements
- R1: After a synchronous active-low reset the status and control registers read zero, every slot address is zero, and `dbg_req` stays low while no access or force is presented.
- R2: With default parameters a write with `wr_en` high loads the slot address registers for `wr_sel` 0 to 3, loads the status register for `wr_sel` 4, and loads the control register for `wr_sel` 5. Codes 6 and 7 change nothing.
- R3: A slot whose kind field is 00 hits when `fetch_valid` is high and `fetch_ip` equals its address exactly. Its length field is not used.
- R4: A slot of kind 01 hits only on data writes (`mem_valid` and `mem_write` high) whose range overlaps the slot's range. Reads never make it hit.
- R5: A slot of kind 11 hits on any data access, read or write, whose range overlaps the slot's range.
- R6: A slot of kind 10 (I/O) never hits.
- R7: For slot i the kind is control bits 17+4i:16+4i and the length code is bits 19+4i:18+4i. Length codes 00, 01, 11 and 10 mean 1, 2, 4 and 8 bytes. The slot range starts at the slot address rounded down to a multiple of that length. The access covers 1, 2, 4 or 8 bytes from `mem_addr` for `mem_size` 0, 1, 2 and 3. A data slot hits when the two ranges share at least one byte.
- R8: Slot i is enabled when control bit 2i (local) or bit 2i+1 (global) is set.
- R9: `dbg_req` is high in exactly the cycles in which an enabled slot hits or `force_upd` is high. It is combinational, so it rises in the cycle the hit is presented and lasts one cycle per such cycle.
- R10: In a cycle with `dbg_req` high, the next edge writes bit i of the status register with the hit of slot i for every slot, enabled or not, and leaves the upper status bits unchanged. In any other cycle without a status write the status register holds its value.
- R11: A status register write through the port in the same cycle as a hit takes priority over the hit capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register index: slots, then status, then control |
| wr_data | input | 32 | Register write data |
| fetch_valid | input | 1 | Instruction fetch present this cycle |
| fetch_ip | input | 32 | Instruction pointer of the fetch |
| mem_valid | input | 1 | Data access present this cycle |
| mem_addr | input | 32 | Data access start address |
| mem_size | input | 2 | Access size code (1, 2, 4, 8 bytes) |
| mem_write | input | 1 | High for write, low for read |
| force_upd | input | 1 | Force status capture and request |
| dbg_req | output | 1 | Debug exception request |
| status_o | output | 32 | Status register |
| ctrl_o | output | 32 | Control register |

## Verification
The bench builds the unit with four slots and 32-bit registers, so the control register is completely filled with enables, kinds and lengths. Every kind and every length code can therefore be programmed at once, one per slot. This brings several cases within reach: hits at both edges of an 8-byte aligned window, reads and writes against a write-only slot, and a silent I/O slot. Multi-slot cycles mixing enabled and disabled hits are also covered. The same configuration exercises a forced capture with no access and the collision of a status write with a capture.

// File: rtl/bpm_pkg.sv
// Shared definitions for the breakpoint match unit.
// Assumes: length and size codes are 2 bits wide.
package bpm_pkg;

    typedef enum logic [1:0] {
        BK_EXEC   = 2'b00,
        BK_WRITE  = 2'b01,
        BK_IO     = 2'b10,
        BK_ACCESS = 2'b11
    } bp_kind_e;

    // Bytes covered by a slot for a given length code.
    function automatic logic [3:0] slot_span(input logic [1:0] code);
        case (code)
            2'b00:   slot_span = 4'd1;
            2'b01:   slot_span = 4'd2;
            2'b11:   slot_span = 4'd4;
            default: slot_span = 4'd8;
        endcase
    endfunction

    // Bytes covered by a data access for a given size code.
    function automatic logic [3:0] access_span(input logic [1:0] code);
        access_span = 4'd1 << code;
    endfunction

endpackage

// File: rtl/bpm_regs.sv
// Register file of the breakpoint unit: slot addresses, control and status.
// Assumes: N_SLOTS < ADDR_W; a port write to status wins over a capture.
module bpm_regs #(
    parameter int N_SLOTS = 4,
    parameter int ADDR_W  = 32,
    parameter int SEL_W   = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [SEL_W-1:0]               wr_sel,
    input  logic [ADDR_W-1:0]              wr_data,
    input  logic                           upd_en,
    input  logic [N_SLOTS-1:0]             hit_vec,
    output logic [N_SLOTS-1:0][ADDR_W-1:0] slot_addr,
    output logic [ADDR_W-1:0]              ctrl_q,
    output logic [ADDR_W-1:0]              status_q
);
    localparam logic [SEL_W-1:0] SEL_STATUS = SEL_W'(N_SLOTS);
    localparam logic [SEL_W-1:0] SEL_CTRL   = SEL_W'(N_SLOTS + 1);

    logic status_wr;
    assign status_wr = wr_en && (wr_sel == SEL_STATUS);

    for (genvar i = 0; i < N_SLOTS; i++) begin : g_addr
        // Load one slot address register.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_addr[i] <= '0;
            else if (wr_en && (wr_sel == SEL_W'(i)))
                slot_addr[i] <= wr_data;
        end
    end

    // Load the control register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_en && (wr_sel == SEL_CTRL))
            ctrl_q <= wr_data;
    end

    // Status: port write first, then hit capture.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_q <= '0;
        else if (status_wr)
            status_q <= wr_data;
        else if (upd_en)
            status_q <= {status_q[ADDR_W-1:N_SLOTS], hit_vec};
    end

    p_sw_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        status_wr |=> status_q == $past(wr_data));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_wr && !upd_en) |=> $stable(status_q));

    p_upper_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !status_wr |=> status_q[ADDR_W-1:N_SLOTS] == $past(status_q[ADDR_W-1:N_SLOTS]));

endmodule

// File: rtl/bpm_ctrl_decode.sv
// Splits the control register into per-slot enable, kind and length fields.
// Assumes: 16 + 4*N_SLOTS <= ADDR_W so every field exists.
module bpm_ctrl_decode #(
    parameter int N_SLOTS = 4,
    parameter int ADDR_W  = 32
) (
    input  logic [ADDR_W-1:0]        ctrl,
    output logic [N_SLOTS-1:0]       en_vec,
    output logic [N_SLOTS-1:0][1:0]  kind,
    output logic [N_SLOTS-1:0][1:0]  len_code
);
    localparam int KIND_BASE = 16;
    localparam int LEN_BASE  = 18;
    localparam int FIELD_STEP = 4;

    for (genvar i = 0; i < N_SLOTS; i++) begin : g_field
        // Either local or global enable arms the slot.
        assign en_vec[i]   = |ctrl[2*i +: 2];
        assign kind[i]     = ctrl[KIND_BASE + FIELD_STEP*i +: 2];
        assign len_code[i] = ctrl[LEN_BASE  + FIELD_STEP*i +: 2];
    end

endmodule

// File: rtl/bpm_slot_cmp.sv
// Comparator for one breakpoint slot: instruction equality or data overlap.
// Assumes: ranges are compared one bit wider than the address so no wrap.
module bpm_slot_cmp
    import bpm_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] slot_addr,
    input  logic [1:0]        kind,
    input  logic [1:0]        len_code,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_ip,
    input  logic              mem_valid,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [1:0]        mem_size,
    input  logic              mem_write,
    output logic              hit
);
    localparam int EXT_W = ADDR_W + 1;

    logic [ADDR_W-1:0] span_mask;
    logic [EXT_W-1:0]  slot_lo, slot_hi, acc_lo, acc_hi;
    logic              overlap;
    bp_kind_e          kind_e;

    // Build the aligned slot window and the access window.
    always_comb begin
        span_mask = ADDR_W'(slot_span(len_code)) - ADDR_W'(1);
        slot_lo   = {1'b0, slot_addr & ~span_mask};
        slot_hi   = slot_lo + EXT_W'(slot_span(len_code));
        acc_lo    = {1'b0, mem_addr};
        acc_hi    = acc_lo + EXT_W'(access_span(mem_size));
        overlap   = (slot_lo < acc_hi) && (acc_lo < slot_hi);
    end

    // Select the match rule by slot kind.
    always_comb begin
        kind_e = bp_kind_e'(kind);
        case (kind_e)
            BK_EXEC:   hit = fetch_valid && (fetch_ip == slot_addr);
            BK_WRITE:  hit = mem_valid && mem_write && overlap;
            BK_ACCESS: hit = mem_valid && overlap;
            default:   hit = 1'b0;
        endcase
    end

    p_io_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == 2'b10) |-> !hit);

    p_read_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == 2'b01 && !mem_write) |-> !hit);

endmodule

// File: rtl/bpm_unit.sv
// Breakpoint match unit top: registers, field decode and per-slot compare.
// Assumes: inputs are synchronous to clk; dbg_req is combinational.
module bpm_unit #(
    parameter  int N_SLOTS = 4,
    parameter  int ADDR_W  = 32,
    localparam int SEL_W   = $clog2(N_SLOTS + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_ip,
    input  logic              mem_valid,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [1:0]        mem_size,
    input  logic              mem_write,
    input  logic              force_upd,
    output logic              dbg_req,
    output logic [ADDR_W-1:0] status_o,
    output logic [ADDR_W-1:0] ctrl_o
);
    logic [N_SLOTS-1:0][ADDR_W-1:0] slot_addr;
    logic [N_SLOTS-1:0]             en_vec;
    logic [N_SLOTS-1:0][1:0]        kind;
    logic [N_SLOTS-1:0][1:0]        len_code;
    logic [N_SLOTS-1:0]             hit_vec;

    bpm_regs #(.N_SLOTS(N_SLOTS), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .upd_en(dbg_req), .hit_vec(hit_vec),
        .slot_addr(slot_addr), .ctrl_q(ctrl_o), .status_q(status_o)
    );

    bpm_ctrl_decode #(.N_SLOTS(N_SLOTS), .ADDR_W(ADDR_W)) u_dec (
        .ctrl(ctrl_o), .en_vec(en_vec), .kind(kind), .len_code(len_code)
    );

    for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
        bpm_slot_cmp #(.ADDR_W(ADDR_W)) u_cmp (
            .clk(clk), .rst_n(rst_n), .slot_addr(slot_addr[i]),
            .kind(kind[i]), .len_code(len_code[i]),
            .fetch_valid(fetch_valid), .fetch_ip(fetch_ip),
            .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_size(mem_size),
            .mem_write(mem_write), .hit(hit_vec[i])
        );
    end

    // Request on any armed hit or on a forced update.
    assign dbg_req = (|(hit_vec & en_vec)) || force_upd;

    p_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_req && !(wr_en && wr_sel == SEL_W'(N_SLOTS)))
            |=> status_o[N_SLOTS-1:0] == $past(hit_vec));

    p_force_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        force_upd |-> dbg_req);

    p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_valid && !mem_valid && !force_upd) |-> !dbg_req);

endmodule

// File: tb/bpm_unit_test.sv
`timescale 1ns/1ps
module bpm_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_ip = '0;
    logic        mem_valid = 1'b0;
    logic [31:0] mem_addr = '0;
    logic [1:0]  mem_size = '0;
    logic        mem_write = 1'b0;
    logic        force_upd = 1'b0;
    logic        dbg_req;
    logic [31:0] status_o, ctrl_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    bit [31:0] m_addr [4];
    bit [31:0] m_ctrl = 0;
    bit [31:0] m_stat = 0;

    always #2 clk = ~clk;

    bpm_unit uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .fetch_valid(fetch_valid), .fetch_ip(fetch_ip),
        .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_write(mem_write), .force_upd(force_upd), .dbg_req(dbg_req),
        .status_o(status_o), .ctrl_o(ctrl_o)
    );

    task automatic check(input string tag, input string what,
                         input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Behavioural hit vector from the model registers and the current inputs.
    function automatic bit [3:0] model_hits();
        bit [3:0] h = 0;
        for (int i = 0; i < 4; i++) begin
            int kd = (m_ctrl >> (16 + 4*i)) & 3;
            int lc = (m_ctrl >> (18 + 4*i)) & 3;
            longint unsigned len = (lc == 0) ? 1 : (lc == 1) ? 2 : (lc == 3) ? 4 : 8;
            longint unsigned lo = m_addr[i] - (m_addr[i] % len);
            longint unsigned hi = lo + len;
            longint unsigned alo = mem_addr;
            longint unsigned ahi = alo + (64'd1 << mem_size);
            bit ov = (lo < ahi) && (alo < hi);
            if (kd == 0) h[i] = fetch_valid && (fetch_ip == m_addr[i]);
            else if (kd == 1) h[i] = mem_valid && mem_write && ov;
            else if (kd == 3) h[i] = mem_valid && ov;
        end
        return h;
    endfunction

    function automatic bit [3:0] model_en();
        bit [3:0] e;
        for (int i = 0; i < 4; i++) e[i] = m_ctrl[2*i] | m_ctrl[2*i+1];
        return e;
    endfunction

    // One cycle: drive after the falling edge, check request, clock, check state.
    task automatic step(input string tag, input bit we, input int sel,
                        input bit [31:0] wd, input bit fv, input bit [31:0] ip,
                        input bit mv, input bit [31:0] ma, input int ms,
                        input bit mw, input bit frc);
        bit [3:0] h;
        bit req;
        wr_en = we; wr_sel = 3'(sel); wr_data = wd;
        fetch_valid = fv; fetch_ip = ip;
        mem_valid = mv; mem_addr = ma; mem_size = 2'(ms); mem_write = mw;
        force_upd = frc;
        #1;
        h = model_hits();
        req = (|(h & model_en())) || frc;
        check(tag, "dbg_req", dbg_req, req);
        @(posedge clk);
        if (we && sel == 4) m_stat = wd;
        else if (req) m_stat = {m_stat[31:4], h};
        if (we && sel < 4) m_addr[sel] = wd;
        if (we && sel == 5) m_ctrl = wd;
        @(negedge clk);
        check(tag, "status", status_o, m_stat);
        check(tag, "ctrl", ctrl_o, m_ctrl);
    endtask

    task automatic idle(input string tag);
        step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic wreg(input string tag, input int sel, input bit [31:0] d);
        step(tag, 1, sel, d, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #40000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) m_addr[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        idle("R1");
        // R2: program slots, status and control through the port
        wreg("R2", 0, 32'h0000_1000);
        wreg("R2", 1, 32'h0000_2002);
        wreg("R2", 2, 32'h0000_3000);
        wreg("R2", 3, 32'h0000_4005);
        wreg("R2", 4, 32'hA5A5_0000);
        // s0 exec/L, s1 write 2B/G, s2 access 8B/L, s3 io 4B/G
        wreg("R2", 5, 32'hEB50_0099);
        wreg("R2", 6, 32'hFFFF_FFFF);
        wreg("R2", 7, 32'h1234_5678);
        // R3: instruction slot exact match and near miss
        step("R3", 0, 0, 0, 1, 32'h1000, 0, 0, 0, 0, 0);
        step("R3", 0, 0, 0, 1, 32'h1001, 0, 0, 0, 0, 0);
        // R4: write slot ignores reads, catches writes
        step("R4", 0, 0, 0, 0, 0, 1, 32'h2002, 1, 0, 0);
        step("R4", 0, 0, 0, 0, 0, 1, 32'h2003, 0, 1, 0);
        // R7: alignment and overlap edges
        step("R7", 0, 0, 0, 0, 0, 1, 32'h2001, 0, 1, 0);
        step("R7", 0, 0, 0, 0, 0, 1, 32'h2000, 2, 1, 0);
        step("R7", 0, 0, 0, 0, 0, 1, 32'h3008, 3, 1, 0);
        step("R7", 0, 0, 0, 0, 0, 1, 32'h2FF9, 3, 0, 0);
        // R5: read-or-write slot catches both kinds
        step("R5", 0, 0, 0, 0, 0, 1, 32'h3007, 0, 0, 0);
        step("R5", 0, 0, 0, 0, 0, 1, 32'h3004, 1, 1, 0);
        // R6: I/O slot stays silent
        step("R6", 0, 0, 0, 0, 0, 1, 32'h4005, 0, 0, 0);
        step("R6", 0, 0, 0, 0, 0, 1, 32'h4004, 2, 1, 0);
        // R8: global enable only on slot 0
        wreg("R8", 5, 32'hEB50_009A);
        step("R8", 0, 0, 0, 1, 32'h1000, 0, 0, 0, 0, 0);
        // R8/R10: disabled slot 0 hits alone, then with an enabled hit
        wreg("R8", 5, 32'hEB50_0098);
        step("R8", 0, 0, 0, 1, 32'h1000, 0, 0, 0, 0, 0);
        step("R10", 0, 0, 0, 1, 32'h1000, 1, 32'h2003, 0, 1, 0);
        // R9: forced update with no access clears the low bits
        step("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        step("R10", 0, 0, 0, 0, 0, 1, 32'h3000, 1, 0, 0);
        idle("R10");
        // R11: status write collides with a hit
        step("R11", 1, 4, 32'h0000_00F0, 0, 0, 1, 32'h3001, 0, 0, 0);
        idle("R11");
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule